// File: doc/BRIEF.md
# Strobed Serial-to-Parallel Register

This block takes a serial bit stream and turns it into a parallel word. Bits enter at `ser_i` on each rising edge of `clk_i` and move one stage per edge from stage 0 toward the last stage. A storage stage sits behind the shifter. It is a level-sensitive latch that follows the shifter while `strobe_i` is high and keeps its last value while `strobe_i` is low. As a result, a stream can be shifted in while the parallel word stays steady, and the new word appears only when the strobe is raised.

The parallel word drives `par_o` while `out_en_i` is high. While `out_en_i` is low, `par_o` is released to high impedance, so several of these blocks can share one bus. Two cascade outputs let blocks be chained into a longer register. `casc_rise_o` is the last shift stage and updates on the rising edge. `casc_fall_o` is the same bit re-timed on the following falling edge, which gives the next block in the chain hold margin when clock edges are slow.

Top module: `sipo_strobe_reg`

## Requirements
- R1: While `rst_ni` is low, the shift stages, the storage latch and both cascade outputs are 0.
- R2: On each rising edge of `clk_i`, stage 0 takes `ser_i` and every stage k>0 takes the old value of stage k-1. Bit k of `par_o` corresponds to stage k.
- R3: While `strobe_i` is high, the storage latch is transparent. `par_o` then follows every shift made during that time.
- R4: While `strobe_i` is low, the storage latch holds its value, and shifting does not change `par_o`.
- R5: While `out_en_i` is high, `par_o` shows the storage latch contents.
- R6: While `out_en_i` is low, every bit of `par_o` is high impedance. Disabling the output does not alter the stored word, which reappears when `out_en_i` returns high.
- R7: `casc_rise_o` equals the last stage and changes only on a rising edge. A bit applied at `ser_i` appears there after WIDTH rising edges.
- R8: On each falling edge, `casc_fall_o` takes the value of `casc_rise_o`. It keeps that value through the following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_i | input | 1 | Serial data in |
| strobe_i | input | 1 | Storage latch transparent while high |
| out_en_i | input | 1 | Parallel output enable, high drives |
| par_o | output | WIDTH | Parallel word, high impedance when disabled |
| casc_rise_o | output | 1 | Last stage, rising-edge cascade out |
| casc_fall_o | output | 1 | Last stage re-timed on falling edge |

## Verification
The bench builds the block with its default WIDTH of 8. This keeps a full fill of the register short, so a single run can cover shifting with the strobe held low, a strobe held high across several shifts, and output disable with re-enable. With a narrow width, the bench can follow every bit to both cascade outputs and compare it there with its own model of the shifter and the latch. It checks the cascade bits at both the rising and the falling edge. Because a two-state simulator reads high impedance as 0, the disabled bus is checked for no bit driven high.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  localparam int unsigned SIPO_WIDTH = 8;
endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
  parameter int unsigned WIDTH = sipo_pkg::SIPO_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  output logic [WIDTH-1:0] stage_o
);
  logic [WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= {stage_q[WIDTH-2:0], ser_i};
  end

  assign stage_o = stage_q;
endmodule

// File: rtl/sipo_store_latch.sv
module sipo_store_latch #(
  parameter int unsigned WIDTH = sipo_pkg::SIPO_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [WIDTH-1:0] stage_i,
  output logic [WIDTH-1:0] store_o
);
  logic [WIDTH-1:0] store_q;

  // transparent while strobe high
  always_latch begin
    if (!rst_ni)       store_q = '0;
    else if (strobe_i) store_q = stage_i;
  end

  assign store_o = store_q;

  // R4
  store_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && $past(!strobe_i)) |-> $stable(store_o));
endmodule

// File: rtl/sipo_fall_retimer.sv
module sipo_fall_retimer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic q_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= d_i;
  end

  assign q_o = q_q;

  // R8: value captured at the falling edge matches the bit seen at the next rise
  fall_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o == d_i);
endmodule

// File: rtl/sipo_strobe_reg.sv
module sipo_strobe_reg #(
  parameter int unsigned WIDTH = sipo_pkg::SIPO_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  input  logic             strobe_i,
  input  logic             out_en_i,
  output logic [WIDTH-1:0] par_o,
  output logic             casc_rise_o,
  output logic             casc_fall_o
);
  localparam int unsigned LAST = WIDTH - 1;

  logic [WIDTH-1:0] stage_w;
  logic [WIDTH-1:0] store_w;

  sipo_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ser_i  (ser_i),
    .stage_o(stage_w)
  );

  sipo_store_latch #(.WIDTH(WIDTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe_i),
    .stage_i (stage_w),
    .store_o (store_w)
  );

  assign casc_rise_o = stage_w[LAST];

  sipo_fall_retimer u_retime (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (casc_rise_o),
    .q_o   (casc_fall_o)
  );

  assign par_o = out_en_i ? store_w : {WIDTH{1'bz}};

  // R6
  bus_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |-> $countones(par_o) == 0);

  // R3
  transparent_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && out_en_i) |-> par_o[LAST] == casc_rise_o);
endmodule

// File: tb/sipo_strobe_reg_tb.sv
module sipo_strobe_reg_tb;
  localparam int unsigned W = 8;
  localparam int unsigned CLK_PERIOD = 10;

  typedef struct {
    logic [W-1:0] par;
    logic         oe;
    logic         rise;
    logic         fall_old;
    string        tag;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ser_i = 1'b0;
  logic strobe_i = 1'b0;
  logic out_en_i = 1'b0;
  logic [W-1:0] par_o;
  logic casc_rise_o, casc_fall_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  exp_t sb_q[$];
  logic [W-1:0] m_shift = '0;
  logic [W-1:0] m_store = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sipo_strobe_reg #(.WIDTH(W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ser_i(ser_i), .strobe_i(strobe_i),
    .out_en_i(out_en_i), .par_o(par_o), .casc_rise_o(casc_rise_o),
    .casc_fall_o(casc_fall_o)
  );

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic chk_par(input string tag, input logic oe, input logic [W-1:0] exp);
    total++;
    if (oe) begin
      if (par_o !== exp) begin
        bad++;
        $display("FAIL %s par act=%b exp=%b", tag, par_o, exp);
      end
    end else begin
      // two-state sims read z as 0: require no bit driven high
      for (int i = 0; i < W; i++) begin
        if (par_o[i] === 1'b1) begin
          bad++;
          $display("FAIL R6 %s par act=%b exp=z", tag, par_o);
          break;
        end
      end
    end
  endtask

  // driver: one rising edge with the given inputs, push expectation
  task automatic step(input logic b, input logic stb, input logic oe, input string tag);
    exp_t e;
    @(negedge clk_i);
    #1;
    ser_i = b; strobe_i = stb; out_en_i = oe;
    if (stb) m_store = m_shift;
    e.fall_old = m_shift[W-1];
    @(posedge clk_i);
    m_shift = {m_shift[W-2:0], b};
    if (stb) m_store = m_shift;
    e.par = m_store; e.oe = oe; e.rise = m_shift[W-1]; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk_i);
      #2;
      if (sb_q.size() != 0) begin
        e = sb_q.pop_front();
        chk_par(e.tag, e.oe, e.par);
        chk_bit("R7 rise", casc_rise_o, e.rise);
        chk_bit("R8 fall before negedge", casc_fall_o, e.fall_old);
        #5;
        chk_bit("R8 fall after negedge", casc_fall_o, e.rise);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] pat;
    // R1 reset state
    out_en_i = 1'b1; ser_i = 1'b1; strobe_i = 1'b1;
    repeat (2) @(posedge clk_i);
    #2;
    chk_par("R1 reset", 1'b1, '0);
    chk_bit("R1 rise", casc_rise_o, 1'b0);
    chk_bit("R1 fall", casc_fall_o, 1'b0);
    @(negedge clk_i); #1;
    strobe_i = 1'b0; ser_i = 1'b0;
    rst_ni = 1'b1;
    // R2 R7 fill with strobe low: par stays 0 (R4)
    pat = 8'b1011_0100;
    for (int i = W - 1; i >= 0; i--) step(pat[i], 1'b0, 1'b1, "R4 hold during fill");
    // R2 one strobed shift exposes stage order
    step(1'b1, 1'b1, 1'b1, "R2 R5 strobed word");
    // R3 strobe held across shifts
    step(1'b0, 1'b1, 1'b1, "R3 transparent 1");
    step(1'b1, 1'b1, 1'b1, "R3 transparent 2");
    step(1'b1, 1'b1, 1'b1, "R3 transparent 3");
    // R4 hold while a new byte shifts in
    pat = 8'b0110_1001;
    for (int i = W - 1; i >= 0; i--) step(pat[i], 1'b0, 1'b1, "R4 hold");
    // R6 disable, keep shifting
    for (int i = 0; i < 3; i++) step(i[0], 1'b0, 1'b0, "R6 released");
    step(1'b0, 1'b0, 1'b1, "R6 word kept");
    step(1'b1, 1'b1, 1'b0, "R6 released while strobed");
    step(1'b0, 1'b0, 1'b1, "R5 new word");
    // R7 single one travels to cascade
    step(1'b1, 1'b0, 1'b1, "R7 marker");
    for (int i = 0; i < W; i++) step(1'b0, 1'b0, 1'b1, "R7 marker walk");
    repeat (3) @(posedge clk_i);
    #8;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule